// File: doc/BRIEF.md
# Pin-State Serial Bridge

This block carries up to 64 parallel signals across one four-wire serial link and brings the answering bits back out as 64 parallel outputs. At the start of each frame it takes a snapshot of the outgoing word. The word comes either from the parallel input pins or from a 64-bit data register that software writes, and a source-select input chooses between them. It then clocks the word out most-significant-bit first. At the same time it collects the bits returned by the far end. When the frame ends, the received word appears on the parallel outputs all at once.

The link timing is fixed at build time by a single clock-divider parameter, so every frame uses the same attribute set. The frame length is set by an input from 4 to 64 bits. A frame begins on a trigger pulse, or back to back while the continuous input is held high. The received word is compared bit by bit against a polarity register under a per-bit enable mask, and any enabled match raises the interrupt output. The data, mask and polarity registers are each written as two 32-bit words through a simple write port.

Top module: `pin_serdes`

## Requirements
- R1: After reset, cs_no is 1, sck_o is 0, par_o is all zero, irq_o is 0 and busy_o is 0.
- R2: During a frame, cs_no is 0. sck_o idles low, rises CLK_DIV clocks after cs_no falls and has a period of 2*CLK_DIV clocks. mosi_o sends frame bit len-1 first and changes only on falling sck_o.
- R3: With cfg_src_reg_i=0 the frame sends pin_i. With cfg_src_reg_i=1 it sends the data register. Data bits 31:0 are written at address 0 and bits 63:32 at address 1.
- R4: pin_i is sampled in the clock cycle in which the frame starts. Later changes to pin_i do not alter the bits sent.
- R5: miso_i is sampled on each rising sck_o. The k-th bit received (k=0 first) lands in par_o[len-1-k]. par_o changes only in the cycle in which cs_no rises, when the whole word updates at once.
- R6: The effective length is cfg_len_i clamped to the range 4..64. par_o bits at and above the effective length are 0 after a frame.
- R7: A frame starts when idle on trig_i=1 or cfg_cont_i=1. A trigger that arrives while busy_o=1 is ignored. Between frames, cs_no stays high for at least CLK_DIV clocks.
- R8: irq_o is 1 exactly when some bit i has mask[i]=1 and par_o[i]=pol[i]. The mask is written at addresses 2 (bits 31:0) and 3 (bits 63:32), the polarity at addresses 4 and 5.
- R9: With the mask all zero, irq_o is 0 for every polarity and received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_len_i | input | 7 | Requested frame length in bits |
| cfg_src_reg_i | input | 1 | 1: send the data register, 0: send pin_i |
| cfg_cont_i | input | 1 | Run frames back to back |
| trig_i | input | 1 | Start one frame when idle |
| pin_i | input | 64 | Parallel inputs to serialize |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register word address |
| wr_data_i | input | 32 | Register write data |
| miso_i | input | 1 | Serial data from the far end |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Frame select, active low |
| mosi_o | output | 1 | Serial data to the far end |
| par_o | output | 64 | Deserialized parallel outputs |
| irq_o | output | 1 | Polarity-match interrupt |
| busy_o | output | 1 | Frame or inter-frame gap in progress |

## Verification
On every cycle, assertions check four things: the serial clock stays low outside a frame, the select line stays high in the inter-frame gap, the parallel outputs hold steady except at the cycle where a frame closes, and the interrupt only changes when its inputs change. Bit ordering, the clock period, the sampling instant of the pins, length clamping, dropping of a trigger while busy, and the polarity/mask match can only be shown by the bench's scenarios. Those scenarios run a model of the far end that records the sent bits and returns a known word.

// File: rtl/pin_serdes_pkg.sv
package pin_serdes_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } eng_state_e;
endpackage

// File: rtl/ps_regs.sv
module ps_regs #(
  parameter int MAX_BITS = 64,
  parameter int WORD_W   = 32,
  localparam int NWORDS  = MAX_BITS / WORD_W,
  localparam int ADDR_W  = $clog2(3 * NWORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [WORD_W-1:0]   wr_data_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic [MAX_BITS-1:0] mask_o,
  output logic [MAX_BITS-1:0] pol_o
);
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WORD_W-1:0] data_q, mask_q, pol_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '0;
        mask_q <= '0;
        pol_q  <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == ADDR_W'(w))            data_q <= wr_data_i;
        if (wr_addr_i == ADDR_W'(NWORDS + w))   mask_q <= wr_data_i;
        if (wr_addr_i == ADDR_W'(2*NWORDS + w)) pol_q  <= wr_data_i;
      end
    end

    assign data_o[w*WORD_W +: WORD_W] = data_q;
    assign mask_o[w*WORD_W +: WORD_W] = mask_q;
    assign pol_o [w*WORD_W +: WORD_W] = pol_q;

    // R3
    data_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == ADDR_W'(w)) |=> (data_o[w*WORD_W +: WORD_W] == $past(wr_data_i)));
  end
endmodule

// File: rtl/ps_engine.sv
module ps_engine
  import pin_serdes_pkg::*;
#(
  parameter int MAX_BITS = 64,
  parameter int CLK_DIV  = 2,
  parameter int MIN_BITS = 4,
  localparam int LEN_W   = $clog2(MAX_BITS + 1),
  localparam int IDX_W   = $clog2(MAX_BITS),
  localparam int CNT_W   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                trig_i,
  input  logic                cont_i,
  input  logic                src_reg_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [MAX_BITS-1:0] pin_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic                miso_i,
  output logic                sck_o,
  output logic                cs_no,
  output logic                mosi_o,
  output logic [MAX_BITS-1:0] par_o,
  output logic                busy_o
);
  eng_state_e           state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [IDX_W-1:0]     idx_q;
  logic [MAX_BITS-1:0]  tx_q, rx_q, par_q;
  logic                 sck_q, cs_n_q;
  logic [LEN_W-1:0]     len_eff;
  logic                 cnt_last;

  always_comb begin
    if (len_i < LEN_W'(MIN_BITS))      len_eff = LEN_W'(MIN_BITS);
    else if (len_i > LEN_W'(MAX_BITS)) len_eff = LEN_W'(MAX_BITS);
    else                               len_eff = len_i;
  end

  assign cnt_last = (cnt_q == CNT_W'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      par_q   <= '0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (trig_i || cont_i) begin
            tx_q    <= src_reg_i ? data_i : pin_i;
            rx_q    <= '0;
            idx_q   <= IDX_W'(len_eff - LEN_W'(1));
            cnt_q   <= '0;
            cs_n_q  <= 1'b0;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (cnt_last) begin
            cnt_q <= '0;
            if (!sck_q) begin
              sck_q       <= 1'b1;
              rx_q[idx_q] <= miso_i;
            end else begin
              sck_q <= 1'b0;
              if (idx_q == '0) begin
                cs_n_q  <= 1'b1;
                par_q   <= rx_q;
                state_q <= ST_GAP;
              end else begin
                idx_q <= idx_q - IDX_W'(1);
              end
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_GAP: begin
          if (cnt_last) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sck_o  = sck_q;
  assign cs_no  = cs_n_q;
  assign mosi_o = !cs_n_q && tx_q[idx_q];
  assign par_o  = par_q;
  assign busy_o = (state_q != ST_IDLE);

  // R2
  sck_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_q |-> !sck_q);
  // R2
  sck_rise_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_q) |-> !cs_n_q);
  // R5
  par_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(cs_n_q) |-> $stable(par_q));
  // R7
  gap_cs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |-> cs_n_q);
endmodule

// File: rtl/ps_irq.sv
module ps_irq #(
  parameter int MAX_BITS = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [MAX_BITS-1:0] par_i,
  input  logic [MAX_BITS-1:0] mask_i,
  input  logic [MAX_BITS-1:0] pol_i,
  output logic                irq_o
);
  logic [MAX_BITS-1:0] hit;

  assign hit   = mask_i & ~(par_i ^ pol_i);
  assign irq_o = |hit;

  // R9
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_o);
  // R8
  irq_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(par_i) && $stable(mask_i) && $stable(pol_i)) |-> $stable(irq_o));
endmodule

// File: rtl/pin_serdes.sv
module pin_serdes #(
  parameter int MAX_BITS = 64,
  parameter int WORD_W   = 32,
  parameter int CLK_DIV  = 2,
  localparam int LEN_W   = $clog2(MAX_BITS + 1),
  localparam int ADDR_W  = $clog2(3 * (MAX_BITS / WORD_W))
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LEN_W-1:0]    cfg_len_i,
  input  logic                cfg_src_reg_i,
  input  logic                cfg_cont_i,
  input  logic                trig_i,
  input  logic [MAX_BITS-1:0] pin_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [WORD_W-1:0]   wr_data_i,
  input  logic                miso_i,
  output logic                sck_o,
  output logic                cs_no,
  output logic                mosi_o,
  output logic [MAX_BITS-1:0] par_o,
  output logic                irq_o,
  output logic                busy_o
);
  logic [MAX_BITS-1:0] data_w, mask_w, pol_w, par_w;

  ps_regs #(.MAX_BITS(MAX_BITS), .WORD_W(WORD_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .data_o    (data_w),
    .mask_o    (mask_w),
    .pol_o     (pol_w)
  );

  ps_engine #(.MAX_BITS(MAX_BITS), .CLK_DIV(CLK_DIV)) i_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig_i),
    .cont_i    (cfg_cont_i),
    .src_reg_i (cfg_src_reg_i),
    .len_i     (cfg_len_i),
    .pin_i     (pin_i),
    .data_i    (data_w),
    .miso_i    (miso_i),
    .sck_o     (sck_o),
    .cs_no     (cs_no),
    .mosi_o    (mosi_o),
    .par_o     (par_w),
    .busy_o    (busy_o)
  );

  ps_irq #(.MAX_BITS(MAX_BITS)) i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .par_i  (par_w),
    .mask_i (mask_w),
    .pol_i  (pol_w),
    .irq_o  (irq_o)
  );

  assign par_o = par_w;
endmodule

// File: tb/test_pin_serdes.sv
`timescale 1ns/1ps
module test_pin_serdes;
  localparam int H = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  cfg_len_i = 7'd16;
  logic        cfg_src_reg_i = 1'b0;
  logic        cfg_cont_i = 1'b0;
  logic        trig_i = 1'b0;
  logic [63:0] pin_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        miso_i = 1'b0;
  logic        sck_o, cs_no, mosi_o, irq_o, busy_o;
  logic [63:0] par_o;

  int checks = 0, errors = 0;
  int blen = 16, k = 0, frames = 0, nrise = 0;
  logic [63:0] sw = '0, cap = '0;
  time last_rise = 0, period = 0;

  always #2 clk_i = ~clk_i;

  pin_serdes i_pin_serdes (.*);

  // far-end model
  always @(negedge cs_no) begin
    frames++; cap = '0; nrise = 0; k = blen - 1; miso_i = sw[k];
  end
  always @(negedge sck_o) begin
    if (k > 0) k--;
    miso_i = sw[k];
  end
  always @(posedge sck_o) begin
    cap = {cap[62:0], mosi_o};
    nrise++;
    period = $time - last_rise;
    last_rise = $time;
  end

  function automatic logic [63:0] lmask(int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  function automatic int clamp(int n);
    return (n < 4) ? 4 : (n > 64) ? 64 : n;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic start_frame(int len, logic [63:0] word);
    while (busy_o) @(negedge clk_i);
    cfg_len_i = 7'(len); blen = clamp(len); sw = word;
    trig_i = 1'b1; @(negedge clk_i); trig_i = 1'b0;
  endtask

  task automatic wait_done();
    @(posedge cs_no); @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk(cs_no === 1'b1 && sck_o === 1'b0 && busy_o === 1'b0, "R1 idle lines", {cs_no, sck_o, busy_o}, 3'b100);
    chk(par_o === '0, "R1 par zero", par_o, '0);
    chk(irq_o === 1'b0, "R1 irq low", irq_o, 0);
  endtask

  task automatic t_pin_frame();
    pin_i = 64'h0000_0000_0000_A5C3;
    cfg_src_reg_i = 1'b0;
    start_frame(16, 64'h0000_0000_0000_3E71);
    wait_done();
    chk(cap === 64'hA5C3, "R3 pins sent msb first", cap, 64'hA5C3);
    chk(par_o === 64'h3E71, "R5 received word", par_o, 64'h3E71);
    chk(nrise == 16, "R2 bit count", nrise, 16);
    chk(period == 2*H*4, "R2 sck period", period, 2*H*4);
  endtask

  task automatic t_first_edge();
    time t0;
    start_frame(8, 64'h5A);
    t0 = $time - 2;  // cs_no fell at the previous posedge
    @(posedge sck_o);
    chk(($time - t0) == H*4, "R2 lead time", $time - t0, H*4);
    chk(cs_no === 1'b0, "R2 cs low in frame", cs_no, 0);
    wait_done();
  endtask

  task automatic t_reg_frame();
    wr(3'd0, 32'hDEAD_BEEF);
    wr(3'd1, 32'h1357_9BDF);
    cfg_src_reg_i = 1'b1;
    pin_i = 64'hFFFF_FFFF_FFFF_FFFF;
    start_frame(64, 64'h0123_4567_89AB_CDEF);
    wait_done();
    chk(cap === 64'h1357_9BDF_DEAD_BEEF, "R3 register source", cap, 64'h1357_9BDF_DEAD_BEEF);
    chk(par_o === 64'h0123_4567_89AB_CDEF, "R5 64-bit receive", par_o, 64'h0123_4567_89AB_CDEF);
    cfg_src_reg_i = 1'b0;
  endtask

  task automatic t_pin_change();
    pin_i = 64'h0000_0000_1234_5678;
    start_frame(32, 64'h0000_0000_CAFE_F00D);
    repeat (6) @(negedge clk_i);
    pin_i = 64'h0000_0000_8765_4321;
    wait_done();
    chk(cap === 64'h1234_5678, "R4 pins sampled at start", cap, 64'h1234_5678);
  endtask

  task automatic t_par_hold();
    logic [63:0] prev;
    prev = par_o;
    start_frame(32, 64'h0000_0000_0F0F_A0A0);
    repeat (20) @(negedge clk_i);
    chk(par_o === prev && busy_o, "R5 par held mid-frame", par_o, prev);
    wait_done();
    chk(par_o === 64'h0F0F_A0A0, "R5 par updated at end", par_o, 64'h0F0F_A0A0);
  endtask

  task automatic t_len_clamp();
    pin_i = 64'hFFFF_FFFF_FFFF_FFFF;
    start_frame(2, 64'hFFFF_FFFF_FFFF_FFFF);
    wait_done();
    chk(nrise == 4, "R6 short length clamps to 4", nrise, 4);
    chk(par_o === 64'hF, "R6 upper bits zero", par_o, 64'hF);
    chk(cap === lmask(4), "R6 four bits sent", cap, lmask(4));
    start_frame(100, 64'h8000_0000_0000_0001);
    wait_done();
    chk(nrise == 64, "R6 long length clamps to 64", nrise, 64);
    chk(par_o === 64'h8000_0000_0000_0001, "R6 full word", par_o, 64'h8000_0000_0000_0001);
  endtask

  task automatic t_trig_busy();
    int f0;
    f0 = frames;
    start_frame(8, 64'h3C);
    repeat (5) @(negedge clk_i);
    trig_i = 1'b1; @(negedge clk_i); trig_i = 1'b0;
    repeat (80) @(negedge clk_i);
    chk(frames == f0 + 1, "R7 trigger while busy ignored", frames, f0 + 1);
  endtask

  task automatic t_cont();
    int f0, f1;
    time trise;
    while (busy_o) @(negedge clk_i);
    cfg_len_i = 7'd4; blen = 4; sw = 64'h9;
    f0 = frames;
    cfg_cont_i = 1'b1;
    @(posedge cs_no); trise = $time;
    @(negedge cs_no);
    chk(($time - trise) >= H*4, "R7 gap length", $time - trise, H*4);
    repeat (150) @(negedge clk_i);
    cfg_cont_i = 1'b0;
    while (busy_o) @(negedge clk_i);
    chk(frames >= f0 + 4, "R7 continuous frames", frames - f0, 4);
    chk(par_o === 64'h9, "R7 continuous data", par_o, 64'h9);
    f1 = frames;
    repeat (60) @(negedge clk_i);
    chk(frames == f1, "R7 stops when cleared", frames, f1);
  endtask

  task automatic t_irq();
    logic [63:0] m, p, e;
    start_frame(64, 64'h0123_4567_89AB_CDEF);
    wait_done();
    wr(3'd4, 32'hFFFF_FFFF); wr(3'd5, 32'hFFFF_FFFF);
    chk(irq_o === 1'b0, "R9 zero mask blocks irq", irq_o, 0);
    wr(3'd3, 32'h0000_0100);          // mask bit 40, par[40]=1
    m = 64'h0000_0100_0000_0000; p = '1;
    e = |(m & ~(par_o ^ p));
    chk(irq_o === e[0], "R8 match raises irq", irq_o, e);
    wr(3'd5, 32'h0000_0000);
    p = 64'h0000_0000_FFFF_FFFF;
    e = |(m & ~(par_o ^ p));
    chk(irq_o === e[0], "R8 polarity mismatch", irq_o, e);
    wr(3'd2, 32'h0000_0001);          // mask bit 0, par[0]=1, pol[0]=1
    m = m | 64'h1;
    e = |(m & ~(par_o ^ p));
    chk(irq_o === e[0], "R8 low word match", irq_o, e);
    wr(3'd2, 32'h0); wr(3'd3, 32'h0);
    chk(irq_o === 1'b0, "R9 cleared mask", irq_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_pin_frame();
    t_first_edge();
    t_reg_frame();
    t_pin_change();
    t_par_hold();
    t_len_clamp();
    t_trig_busy();
    t_cont();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule